// File: doc/BRIEF.md
# Periodically Sampled Pseudorandom Display Source

This block runs a 16-bit linear feedback shift register that advances on every clock and produces a pseudorandom sequence. A down-counter decides when the current register value is copied into a 16-bit display latch. Between copies the latch holds, so the value changes slowly enough to be read by eye on LEDs and hex digits.

Software sets the capture interval through a single-address register port. The port has a write strobe, write data, a read strobe and registered read data, and the value written can be read back. A pushbutton input passes through a two-flop synchronizer. While the button is held, the latch freezes. The latched word is split into four 4-bit fields: two hex digits and two LED groups.

Top module: `prng_display_src`

## Requirements
- R1: During reset and on the first sampled cycle after it, all four display fields read 0. A read of the period register then returns the default period parameter (25,000,000 unless overridden), and read data is 0.
- R2: The shift register starts from the seed 16'hACE1 and advances every cycle to `{s[14:0], s[15]^s[13]^s[12]^s[10]}`, which is a maximal-length 16-bit sequence. With an effective period of 1 and the button released, each latched value is this step applied to the previous latched value, and the latch never holds zero after its first capture.
- R3: A capture happens on every Pth clock, where P is the effective period. The counter counts down from P-1 and captures when it reaches 0. Between captures the latch keeps its value.
- R4: A write strobe stores the 32-bit write data in the period register. A read strobe presented in one cycle returns the period register's value on read data after the next clock edge; read data is 0 after a cycle without a read strobe. A read issued together with a write returns the old value.
- R5: A period value of 0 behaves as 1, so the latch captures on every clock.
- R6: A new period value does not restart the count in progress. It is loaded into the counter at the next capture point.
- R7: The button is sampled through two flops. A button level present at clock edge k gates captures from edge k+2 onward. While the synchronized level is high, capture points pass without updating the latch, and the counter keeps running.
- R8: The field outputs are: left hex = latch[15:12], right hex = latch[11:8], red LEDs = latch[7:4], green LEDs = latch[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_freeze | input | 1 | Asynchronous pushbutton; high freezes the latch |
| reg_wr_en | input | 1 | Period register write strobe |
| reg_wr_data | input | 32 | Period write value |
| reg_rd_en | input | 1 | Period register read strobe |
| reg_rd_data | output | 32 | Registered read data, valid one cycle after the strobe |
| hex_left | output | 4 | Latch bits 15:12 |
| hex_right | output | 4 | Latch bits 11:8 |
| led_red | output | 4 | Latch bits 7:4 |
| led_green | output | 4 | Latch bits 3:0 |

## Verification
The assertions assume that reset is held for at least one clock. They also assume the counter compares and reload steps see a period register that changes only through the write strobe, so that the reload value can be derived from the period one cycle earlier. The stimulus drives every input half a cycle away from the active edge, which keeps the synchronizer timing deterministic. It writes only small periods, including 0, so that many capture points and mid-count period changes occur in a short run. The default period is overridden to a small value in the bench so that the first reload after reset is reached quickly.

// File: rtl/prng_display_src.sv
module prng_display_src #(
  parameter int          LFSR_W         = 16,
  parameter logic [15:0] SEED           = 16'hACE1,
  parameter int          PERIOD_W       = 32,
  parameter int          DEFAULT_PERIOD = 25_000_000,
  parameter int          FIELD_W        = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                btn_freeze,
  input  logic                reg_wr_en,
  input  logic [PERIOD_W-1:0] reg_wr_data,
  input  logic                reg_rd_en,
  output logic [PERIOD_W-1:0] reg_rd_data,
  output logic [FIELD_W-1:0]  hex_left,
  output logic [FIELD_W-1:0]  hex_right,
  output logic [FIELD_W-1:0]  led_red,
  output logic [FIELD_W-1:0]  led_green
);

  localparam logic [PERIOD_W-1:0] DEF_P   = PERIOD_W'(DEFAULT_PERIOD);
  localparam logic [PERIOD_W-1:0] DEF_CNT = (DEF_P == '0) ? '0 : DEF_P - 1'b1;

  logic [LFSR_W-1:0]   lfsr_q;
  logic [LFSR_W-1:0]   shown_q;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [1:0]          btn_sync_q;
  logic                btn_s;
  logic                tick;
  logic                feedback;
  logic [PERIOD_W-1:0] reload;

  assign feedback = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign btn_s    = btn_sync_q[1];
  assign tick     = (cnt_q == '0);
  assign reload   = (period_q == '0) ? '0 : period_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= SEED;
    else     lfsr_q <= {lfsr_q[LFSR_W-2:0], feedback};
  end

  always_ff @(posedge clk) begin
    if (rst) btn_sync_q <= '0;
    else     btn_sync_q <= {btn_sync_q[0], btn_freeze};
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= DEF_CNT;
    else if (tick) cnt_q <= reload;
    else           cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 shown_q <= '0;
    else if (tick && !btn_s) shown_q <= lfsr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)            period_q <= DEF_P;
    else if (reg_wr_en) period_q <= reg_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rd_data <= '0;
    else     reg_rd_data <= reg_rd_en ? period_q : '0;
  end

  assign hex_left  = shown_q[15:12];
  assign hex_right = shown_q[11:8];
  assign led_red   = shown_q[7:4];
  assign led_green = shown_q[3:0];

endmodule

// File: rtl/prng_display_src_chk.sv
module prng_display_src_chk #(
  parameter int PERIOD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [15:0]         lfsr_q,
  input logic [15:0]         shown_q,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic                btn_s,
  input logic                reg_rd_en,
  input logic [PERIOD_W-1:0] reg_rd_data,
  input logic [3:0]          hex_left,
  input logic [3:0]          led_green
);

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 16'h0);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(shown_q));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_readback_R4: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> (reg_rd_data == $past(period_q)));

  assert_zero_as_one_R5: assert property (@(posedge clk) disable iff (rst)
    ((period_q == '0) && (cnt_q == '0)) |=> (cnt_q == '0));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && (period_q != '0)) |=> (cnt_q == $past(period_q) - 1'b1));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    btn_s |=> $stable(shown_q));

  assert_fields_R8: assert property (@(posedge clk) disable iff (rst)
    (hex_left == shown_q[15:12]) && (led_green == shown_q[3:0]));

endmodule

bind prng_display_src prng_display_src_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .lfsr_q(lfsr_q), .shown_q(shown_q), .cnt_q(cnt_q),
  .period_q(period_q), .btn_s(btn_s), .reg_rd_en(reg_rd_en),
  .reg_rd_data(reg_rd_data), .hex_left(hex_left), .led_green(led_green)
);

// File: tb/prng_display_src_bench.sv
`timescale 1ns/1ps
module prng_display_src_bench;
  localparam int DEF_P = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  hl, hr, lr, lg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  prng_display_src #(.DEFAULT_PERIOD(DEF_P)) u_prng_display_src (
    .clk(clk), .rst(rst), .btn_freeze(btn), .reg_wr_en(wr_en),
    .reg_wr_data(wr_data), .reg_rd_en(rd_en), .reg_rd_data(rd_data),
    .hex_left(hl), .hex_right(hr), .led_red(lr), .led_green(lg)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [31:0] eff(input logic [31:0] p);
    return (p == 0) ? 32'd1 : p;
  endfunction

  // reference model from the requirements
  logic [15:0] m_lfsr, m_shown;
  logic [31:0] m_period, m_cnt, m_rd;
  logic [1:0]  m_sync;
  always @(posedge clk) begin
    if (rst) begin
      m_lfsr <= 16'hACE1; m_shown <= '0; m_period <= DEF_P;
      m_cnt <= DEF_P - 1; m_rd <= '0; m_sync <= '0;
    end else begin
      m_lfsr <= step(m_lfsr);
      m_sync <= {m_sync[0], btn};
      if (m_cnt == 0) begin
        m_cnt <= eff(m_period) - 1;
        if (!m_sync[1]) m_shown <= m_lfsr;
      end else m_cnt <= m_cnt - 1;
      if (wr_en) m_period <= wr_data;
      m_rd <= rd_en ? m_period : '0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] shown();
    return {hl, hr, lr, lg};
  endfunction

  task automatic compare_all();
    check("R8 hex_left",  {28'd0, hl}, {28'd0, m_shown[15:12]});
    check("R8 hex_right", {28'd0, hr}, {28'd0, m_shown[11:8]});
    check("R8 led_red",   {28'd0, lr}, {28'd0, m_shown[7:4]});
    check("R3/R6/R7 led_green", {28'd0, lg}, {28'd0, m_shown[3:0]});
    check("R4 rd_data", rd_data, m_rd);
  endtask

  task automatic write_period(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1 reset fields", {16'd0, shown()}, 32'd0);
    rst = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    check("R1 fields after reset", {16'd0, shown()}, 32'd0);
    check("R1 default period readback", rd_data, DEF_P);
    rd_en = 1'b0;
    @(negedge clk);
    check("R4 rd_data zero without strobe", rd_data, 32'd0);

    // R2: period 1, recurrence over latched values
    write_period(32'd1);
    repeat (DEF_P + 2) @(negedge clk);
    prev = shown();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R2 step", {16'd0, shown()}, {16'd0, step(prev)});
      check("R2 nonzero", {31'd0, shown() != 16'd0}, 32'd1);
      prev = shown();
    end

    // R5: period 0 acts as 1
    write_period(32'd0);
    repeat (3) @(negedge clk);
    prev = shown();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R5 zero period captures every cycle", {16'd0, shown()}, {16'd0, step(prev)});
      prev = shown();
    end

    // R7: freeze with two-flop lag
    btn = 1'b1;
    @(negedge clk); prev = shown();
    check("R7 capture at edge k", {16'd0, prev}, {16'd0, m_shown});
    @(negedge clk);
    check("R7 capture at edge k+1", {16'd0, shown()}, {16'd0, step(prev)});
    prev = shown();
    repeat (8) @(negedge clk);
    check("R7 frozen", {16'd0, shown()}, {16'd0, prev});
    btn = 1'b0;
    @(negedge clk);
    check("R7 still frozen one edge after release", {16'd0, shown()}, {16'd0, prev});
    @(negedge clk);
    check("R7 resumes", {16'd0, shown()}, {16'd0, m_shown});

    // R4: read together with write returns old value
    @(negedge clk); wr_en = 1'b1; wr_data = 32'd5; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R4 read-during-write old value", rd_data, 32'd0);
    @(negedge clk); rd_en = 1'b0;
    check("R4 readback", rd_data, 32'd5);

    // random mix, lockstep with model (R3, R6, R7, R8)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      wr_en   = ($urandom % 40) == 0;
      wr_data = $urandom % 24;
      rd_en   = $urandom % 2;
      if (($urandom % 60) == 0) btn = ~btn;
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule